// File: doc/BRIEF.md
# Miss Holding Slot with Parked Requests

This block is one outstanding-miss slot for a single cache block address. While a fetch for that block is on its way, the slot collects every request that hits the same block. Processor requests that the fetch already in flight can serve join a primary list. Processor requests it cannot serve are parked on a second list. Bus snoops that hit the slot are handled in one of three ways: they are ignored, they are kept as a duty to supply data once the block arrives, or they are recorded as a mark that the block will be taken away.

When the fill arrives, the slot walks its primary list one entry per cycle, in arrival order. Each processor entry produces a response that says whether it completes at the first-word time or at the full-transfer time. Each snoop entry produces a snoop-service pulse. If anything is parked, the parked list becomes the new primary list and the slot asks for the bus again, this time with the exclusivity the parked requests need. Otherwise the slot reports that it is finished and can be released.

Top module: `mshr_slot`

## Requirements
- R1: After reset the slot is free: `bus_req_o`, `done_o`, `blocked_o`, `resp_valid_o` and `snp_serve_o` are all low. A pulse on `alloc_i` while the slot is free stores the request on `cpu_*` as the only target and raises `bus_req_o` from the next cycle. `bus_excl_o` then equals that request's `cpu_excl_i`.
- R2: A processor push made before `issue_i` joins the primary list. If that push has `cpu_excl_i` = 1, `bus_excl_o` is high from the next cycle on.
- R3: After `issue_i`, a processor push is parked in any of three cases: the parked list already holds an entry, the block is marked as going away, or the push needs exclusivity while `bus_excl_o` is low.
- R4: After `issue_i`, a processor push that meets none of the parking conditions in R3 joins the primary list behind the existing entries.
- R5: After `issue_i`, with `bus_excl_o` high and no going-away mark, a snoop push raises `mem_inhibit_o` in the same cycle and is kept on the primary list as a snoop entry.
- R6: After `issue_i`, with `bus_excl_o` low, a snoop with `snp_excl_i` = 1 is kept as a snoop entry and sets the going-away mark. While that mark is set, later snoops are ignored and never raise `mem_inhibit_o`.
- R7: After `issue_i`, with `bus_excl_o` low and no going-away mark, a snoop with `snp_excl_i` = 0 is dropped and is not stored.
- R8: A pulse on `fill_i` after `issue_i` starts the drain. From the next cycle, one primary entry is presented per cycle in arrival order. A processor entry raises `resp_valid_o` with its tag on `resp_tag_o`. A snoop entry raises `snp_serve_o`.
- R9: `resp_late_o` is 0 when the entry's block offset, minus the first request's offset, taken modulo the block size, is zero. It is 1 for any other value.
- R10: When the primary list is empty and parked entries exist, the parked list becomes the primary list one cycle later. At that point `bus_req_o` rises again, `bus_excl_o` becomes 1 exactly when some parked request needed exclusivity, and the going-away mark is cleared.
- R11: When both lists are empty after a drain, `done_o` rises. `dealloc_i` frees the slot only while `done_o` is high, and it is ignored at any other time.
- R12: `blocked_o` is high while the slot holds `MAX_TGT` targets across both lists. While it is high, a push that would have been stored is refused: `push_err_o` pulses in the next cycle, no target is added, and no `mem_inhibit_o` is raised.
- R13: A snoop push before `issue_i`, and any push while the slot is free or draining, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Claim the free slot with the request on cpu_* |
| dealloc_i | input | 1 | Release the slot after it has finished |
| cpu_push_i | input | 1 | Processor request for this block |
| cpu_excl_i | input | 1 | Processor request needs an exclusive copy |
| cpu_tag_i | input | TAG_W | Request identifier returned with the response |
| cpu_off_i | input | OFF_W | Byte offset of the request within the block |
| snp_push_i | input | 1 | Bus snoop hitting this block |
| snp_excl_i | input | 1 | Snoop takes ownership (invalidating) |
| issue_i | input | 1 | Bus accepted the slot's request |
| fill_i | input | 1 | Block data has arrived; start draining |
| bus_req_o | output | 1 | Slot wants the memory-side bus |
| bus_excl_o | output | 1 | Request asks, or asked, for an exclusive copy |
| mem_inhibit_o | output | 1 | This slot will supply the snooped data |
| resp_valid_o | output | 1 | Processor response presented this cycle |
| resp_tag_o | output | TAG_W | Tag of the response |
| resp_late_o | output | 1 | Response completes at full-transfer time |
| snp_serve_o | output | 1 | Deferred snoop handled this cycle |
| done_o | output | 1 | All targets served; slot may be released |
| blocked_o | output | 1 | Target storage full |
| push_err_o | output | 1 | A push was refused in the previous cycle |

## Verification
The drain is driven by several different target mixes. In the first, all requests are compatible with an exclusive fetch, so the test shows that ordering is kept and that a stored snoop is served after the processor entries that came before it. In the second, a shared fetch is followed by an exclusive request and then a plain read; this separates parking on incompatibility from parking only because an entry is already parked, and the second drain shows that promotion carried the exclusivity. In the third, an invalidating snoop sets the going-away mark; this shows that later reads are parked, later snoops are ignored, and the mark is gone after promotion. A full-slot run checks that refusals come with no side effect, and offsets chosen below and above the first request's offset check the modulo wrap of the late flag.

// File: rtl/mshr_slot_pkg.sv
package mshr_slot_pkg;

  typedef enum logic [2:0] {
    SL_FREE  = 3'd0,
    SL_WAIT  = 3'd1,
    SL_FLY   = 3'd2,
    SL_DRAIN = 3'd3,
    SL_DONE  = 3'd4
  } slot_st_e;

endpackage

// File: rtl/mshr_slot_fifo.sv
module mshr_slot_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout = mem[rd_q];

  p_fifo_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));
  p_fifo_nonempty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/mshr_slot_route.sv
module mshr_slot_route (
  input  logic st_wait,
  input  logic st_fly,
  input  logic needs_excl,
  input  logic going_away,
  input  logic parked_any,
  input  logic full,
  input  logic cpu_push,
  input  logic cpu_excl,
  input  logic snp_push,
  input  logic snp_excl,
  output logic snp_store,
  output logic snp_inhibit,
  output logic snp_mark,
  output logic cpu_store,
  output logic cpu_park,
  output logic refused
);
  logic snp_want, cpu_want;

  always_comb begin
    // a snoop is worth keeping only with an exclusive fetch or when it steals the block
    snp_want    = snp_push && st_fly && !going_away && (needs_excl || snp_excl);
    snp_store   = snp_want && !full;
    snp_inhibit = snp_store && needs_excl;
    snp_mark    = snp_store && !needs_excl;
    cpu_want    = cpu_push && (st_wait || st_fly) && !snp_want;
    cpu_park    = st_fly && (parked_any || going_away || (!needs_excl && cpu_excl));
    cpu_store   = cpu_want && !full;
    refused     = (snp_want || cpu_want) && full;
  end
endmodule

// File: rtl/mshr_slot.sv
module mshr_slot
  import mshr_slot_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int BLK_BYTES = 8,
  parameter int MAX_TGT   = 4,
  parameter int OFF_W     = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             dealloc_i,
  input  logic             cpu_push_i,
  input  logic             cpu_excl_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  input  logic [OFF_W-1:0] cpu_off_i,
  input  logic             snp_push_i,
  input  logic             snp_excl_i,
  input  logic             issue_i,
  input  logic             fill_i,
  output logic             bus_req_o,
  output logic             bus_excl_o,
  output logic             mem_inhibit_o,
  output logic             resp_valid_o,
  output logic [TAG_W-1:0] resp_tag_o,
  output logic             resp_late_o,
  output logic             snp_serve_o,
  output logic             done_o,
  output logic             blocked_o,
  output logic             push_err_o
);
  localparam int CW = $clog2(MAX_TGT+1);
  localparam int EW = 1 + OFF_W + TAG_W;

  // offset of a target past the first request, wrapping at the block size
  function automatic logic [OFF_W-1:0] rel_off(input logic [OFF_W-1:0] off,
                                               input logic [OFF_W-1:0] first);
    return off - first;
  endfunction

  slot_st_e        st;
  logic            sel;          // which bank is the primary list
  logic            needs_excl, park_excl, going_away, err_q;
  logic [OFF_W-1:0] first_off;

  logic [1:0]          bpush, bpop;
  logic [1:0][EW-1:0]  bdin, bdout;
  logic [1:0][CW-1:0]  bcnt;
  logic [CW-1:0]       prim_cnt, park_cnt, total;
  logic                full;

  logic snp_store, snp_inhibit, snp_mark, cpu_store, cpu_park, refused;
  logic alloc_go, prim_push, park_push, drain_pop, promote;
  logic [EW-1:0] cpu_word, snp_word, prim_word, head;
  logic          head_snp;

  assign prim_cnt = bcnt[sel];
  assign park_cnt = bcnt[~sel];
  assign total    = bcnt[0] + bcnt[1];
  assign full     = (total == CW'(MAX_TGT));

  mshr_slot_route u_route (
    .st_wait    (st == SL_WAIT),
    .st_fly     (st == SL_FLY),
    .needs_excl (needs_excl),
    .going_away (going_away),
    .parked_any (park_cnt != '0),
    .full       (full),
    .cpu_push   (cpu_push_i),
    .cpu_excl   (cpu_excl_i),
    .snp_push   (snp_push_i),
    .snp_excl   (snp_excl_i),
    .snp_store  (snp_store),
    .snp_inhibit(snp_inhibit),
    .snp_mark   (snp_mark),
    .cpu_store  (cpu_store),
    .cpu_park   (cpu_park),
    .refused    (refused)
  );

  assign alloc_go  = alloc_i && (st == SL_FREE);
  assign cpu_word  = {1'b0, cpu_off_i, cpu_tag_i};
  assign snp_word  = {1'b1, {OFF_W{1'b0}}, {TAG_W{1'b0}}};
  assign prim_push = alloc_go || snp_store || (cpu_store && !cpu_park);
  assign park_push = cpu_store && cpu_park;
  assign prim_word = snp_store ? snp_word : cpu_word;
  assign drain_pop = (st == SL_DRAIN) && (prim_cnt != '0);
  assign promote   = (st == SL_DRAIN) && (prim_cnt == '0) && (park_cnt != '0);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bpush[b] = (sel == 1'(b)) ? prim_push : park_push;
    assign bdin[b]  = (sel == 1'(b)) ? prim_word : cpu_word;
    assign bpop[b]  = (sel == 1'(b)) && drain_pop;
    mshr_slot_fifo #(.DEPTH(MAX_TGT), .W(EW)) u_q (
      .clk (clk),
      .rst_n(rst_n),
      .push(bpush[b]),
      .din (bdin[b]),
      .pop (bpop[b]),
      .dout(bdout[b]),
      .cnt (bcnt[b])
    );
  end

  assign head     = bdout[sel];
  assign head_snp = head[EW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SL_FREE;
      sel        <= 1'b0;
      needs_excl <= 1'b0;
      park_excl  <= 1'b0;
      going_away <= 1'b0;
      first_off  <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= refused;
      case (st)
        SL_FREE: if (alloc_go) begin
          st         <= SL_WAIT;
          needs_excl <= cpu_excl_i;
          park_excl  <= 1'b0;
          going_away <= 1'b0;
          first_off  <= cpu_off_i;
        end
        SL_WAIT: begin
          if (cpu_store && cpu_excl_i) needs_excl <= 1'b1;
          if (issue_i) st <= SL_FLY;
        end
        SL_FLY: begin
          if (park_push && cpu_excl_i) park_excl <= 1'b1;
          if (snp_mark) going_away <= 1'b1;
          if (fill_i) st <= SL_DRAIN;
        end
        SL_DRAIN: begin
          if (promote) begin
            sel        <= ~sel;
            needs_excl <= park_excl;
            park_excl  <= 1'b0;
            going_away <= 1'b0;
            st         <= SL_WAIT;
          end else if (prim_cnt == '0) begin
            st <= SL_DONE;
          end
        end
        SL_DONE: if (dealloc_i) st <= SL_FREE;
        default: st <= SL_FREE;
      endcase
    end
  end

  assign bus_req_o     = (st == SL_WAIT);
  assign bus_excl_o    = needs_excl;
  assign mem_inhibit_o = snp_inhibit;
  assign resp_valid_o  = drain_pop && !head_snp;
  assign snp_serve_o   = drain_pop && head_snp;
  assign resp_tag_o    = head[TAG_W-1:0];
  assign resp_late_o   = (rel_off(head[TAG_W +: OFF_W], first_off) != '0);
  assign done_o        = (st == SL_DONE);
  assign blocked_o     = full;
  assign push_err_o    = err_q;

  p_count_limit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    total <= CW'(MAX_TGT));
  p_err_when_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_err_o |-> $past(blocked_o));
  p_inhibit_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit_o |-> (snp_push_i && bus_excl_o && st == SL_FLY));
  p_mark_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(going_away) |-> $past(snp_push_i && snp_excl_i && !needs_excl));
  p_drain_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_pop |=> (total == $past(total) - 1'b1));
  p_promote_rereq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    promote |=> (bus_req_o && !going_away));
  p_done_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (total == '0));
endmodule

// File: tb/sim_mshr_slot.sv
`timescale 1ns/1ps
module sim_mshr_slot;
  localparam int TAG_W = 4, BLK = 8, MAXT = 4, OFF_W = 3;
  localparam int SNP = 99;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_i = 0, dealloc_i = 0, cpu_push_i = 0, cpu_excl_i = 0;
  logic [TAG_W-1:0] cpu_tag_i = '0;
  logic [OFF_W-1:0] cpu_off_i = '0;
  logic snp_push_i = 0, snp_excl_i = 0, issue_i = 0, fill_i = 0;
  logic bus_req_o, bus_excl_o, mem_inhibit_o, resp_valid_o, resp_late_o;
  logic snp_serve_o, done_o, blocked_o, push_err_o;
  logic [TAG_W-1:0] resp_tag_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mshr_slot #(.TAG_W(TAG_W), .BLK_BYTES(BLK), .MAX_TGT(MAXT)) u0 (.*);

  function automatic int code(int tag, int off, int first);
    int rel = (((off - first) % BLK) + BLK) % BLK;
    return tag * 2 + ((rel != 0) ? 1 : 0);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic alloc(input int tag, input bit ex, input int off);
    alloc_i = 1; cpu_tag_i = TAG_W'(tag); cpu_excl_i = ex; cpu_off_i = OFF_W'(off);
    @(negedge clk); alloc_i = 0;
  endtask

  task automatic cpu(input int tag, input bit ex, input int off);
    cpu_push_i = 1; cpu_tag_i = TAG_W'(tag); cpu_excl_i = ex; cpu_off_i = OFF_W'(off);
    @(negedge clk); cpu_push_i = 0;
  endtask

  task automatic snoop(input bit ex, output bit inh);
    snp_push_i = 1; snp_excl_i = ex;
    #1 inh = mem_inhibit_o;
    @(negedge clk); snp_push_i = 0;
  endtask

  task automatic issue();
    issue_i = 1; @(negedge clk); issue_i = 0;
  endtask

  task automatic fill();
    fill_i = 1; @(negedge clk); fill_i = 0;
  endtask

  task automatic free();
    dealloc_i = 1; @(negedge clk); dealloc_i = 0;
  endtask

  task automatic drain_expect(input string r, input int n, input int e[4]);
    int k = 0;
    int got;
    for (int i = 0; i < 6; i++) begin
      if (resp_valid_o) got = int'(resp_tag_o) * 2 + int'(resp_late_o);
      else if (snp_serve_o) got = SNP;
      else break;
      chk(r, got, (k < n) ? e[k] : -1);
      k++;
      @(negedge clk);
    end
    chk({r, " entries"}, k, n);
  endtask

  task automatic t_reset();
    chk("R1 bus_req idle", bus_req_o, 0);
    chk("R1 done idle", done_o, 0);
    chk("R1 blocked idle", blocked_o, 0);
    chk("R1 no output", resp_valid_o | snp_serve_o, 0);
  endtask

  task automatic t_exclusive_mix();
    bit inh;
    alloc(1, 0, 2);
    chk("R1 bus_req after alloc", bus_req_o, 1);
    chk("R1 shared fetch", bus_excl_o, 0);
    cpu(2, 1, 2);
    chk("R2 excl before issue", bus_excl_o, 1);
    issue();
    chk("R1 req drops on issue", bus_req_o, 0);
    cpu(3, 0, 5);                          // R4 joins primary
    snoop(0, inh);
    chk("R5 inhibit", inh, 1);
    fill();
    drain_expect("R8 R9 R4 R5 order", 4, '{code(1,2,2), code(2,2,2), code(3,5,2), SNP});
    @(negedge clk);
    chk("R11 done", done_o, 1);
    chk("R11 no rereq", bus_req_o, 0);
    free();
    chk("R11 freed", done_o, 0);
  endtask

  task automatic t_parking();
    bit inh;
    alloc(4, 0, 6);
    issue();
    cpu(5, 0, 1);                          // R4 compatible
    cpu(6, 1, 6);                          // R3 incompatible
    cpu(7, 0, 7);                          // R3 parked behind parked entry
    snoop(0, inh);
    chk("R7 plain snoop no inhibit", inh, 0);
    fill();
    drain_expect("R3 R7 R9 first drain", 2, '{code(4,6,6), code(5,1,6), 0, 0});
    @(negedge clk);
    chk("R10 rereq", bus_req_o, 1);
    chk("R10 excl carried", bus_excl_o, 1);
    chk("R10 not done", done_o, 0);
    issue();
    fill();
    drain_expect("R3 R10 second drain", 2, '{code(6,6,6), code(7,7,6), 0, 0});
    @(negedge clk);
    chk("R11 done after second", done_o, 1);
    free();
  endtask

  task automatic t_going_away();
    bit inh;
    alloc(8, 0, 0);
    issue();
    snoop(1, inh);
    chk("R6 steal no inhibit", inh, 0);
    cpu(9, 0, 0);                          // R6 parked by mark
    snoop(1, inh);
    chk("R6 later snoop ignored", inh, 0);
    fill();
    drain_expect("R6 drain", 2, '{code(8,0,0), SNP, 0, 0});
    @(negedge clk);
    chk("R10 rereq after mark", bus_req_o, 1);
    chk("R10 shared refetch", bus_excl_o, 0);
    issue();
    snoop(1, inh);                         // mark cleared: stored again
    fill();
    drain_expect("R10 mark cleared", 2, '{code(9,0,0), SNP, 0, 0});
    @(negedge clk);
    chk("R11 done mark", done_o, 1);
    free();
  endtask

  task automatic t_full();
    bit inh;
    alloc(1, 1, 0);
    cpu(2, 0, 1);
    cpu(3, 0, 2);
    chk("R12 not yet blocked", blocked_o, 0);
    cpu(4, 0, 3);
    chk("R12 blocked", blocked_o, 1);
    cpu(5, 0, 4);
    chk("R12 refuse err", push_err_o, 1);
    @(negedge clk);
    chk("R12 err pulse", push_err_o, 0);
    issue();
    snoop(0, inh);
    chk("R12 no inhibit when full", inh, 0);
    chk("R12 snoop refused", push_err_o, 1);
    fill();
    drain_expect("R12 contents", 4, '{code(1,0,0), code(2,1,0), code(3,2,0), code(4,3,0)});
    @(negedge clk);
    chk("R12 done", done_o, 1);
    free();
  endtask

  task automatic t_ignored();
    bit inh;
    snoop(1, inh);                         // free slot
    cpu(11, 1, 0);
    chk("R13 free push ignored", bus_req_o, 0);
    alloc(3, 0, 0);
    snoop(1, inh);                         // before issue
    chk("R13 early snoop no inhibit", inh, 0);
    free();
    chk("R11 dealloc ignored", bus_req_o, 1);
    issue();
    fill();
    cpu(12, 0, 0);                         // during drain, ignored
    drain_expect("R13 nothing extra", 0, '{0, 0, 0, 0});
    @(negedge clk);
    chk("R13 done no promote", done_o, 1);
    free();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exclusive_mix();
    t_parking();
    t_going_away();
    t_full();
    t_ignored();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule